// File: doc/BRIEF.md
# Configuration Address Translator

This block sits between a host bridge's configuration data port and the configuration targets behind it. Software first loads a raw address word into a bridge-specific register, which lives outside this block. The block takes that word and the low address bits of each data-port access, and rebuilds them into a standard configuration address. In that address the device number starts at bit 11, the function number is in bits 10:8 and the register offset is in bits 7:0. The block then issues the read or write downstream with its length and data. It handles one transaction at a time.

Three raw encodings are recognised, in strict priority. An already-enabled word (top bit set) passes straight through. A word tagged in bit 0 is taken as already formatted for a remote bus. Any other word carries a one-hot slot select in its upper bits, and the lowest set bit of that field becomes a binary device number. When no slot bit is set, nothing is sent downstream: the access completes locally as a master abort. Reads that end this way return all ones.

A parameter selects big-endian operation. In that mode the write data is byte-reversed within the access length before it goes downstream, and the read data is byte-reversed the same way when it comes back.

Top module: `cfgx_bridge`

## Requirements
- R1: When raw bit 31 is set, the downstream address equals the raw word ORed with data-port address bits [1:0]. Data-port bit 2 is ignored, and this form wins over every other form, even when raw bit 0 is also set.
- R2: When raw bit 31 is clear and raw bit 0 is set, the downstream address is raw bits [31:3] followed by data-port address bits [2:0].
- R3: When raw bits 31 and 0 are both clear, the downstream address is built from four fields, shown in the table after this list. The lowest set raw bit at or above bit 11 decides the device number, so a word with several slot bits set selects the lowest of them.
- R4: A slot-select word with no set bit in raw [31:11] sends nothing downstream. The access completes with `done_abort` high, a write is discarded, and a read returns 32'hFFFF_FFFF.
- R5: Accesses are forwarded downstream whenever R4 does not apply, with no check of raw bit 31.
- R6: Length codes are 2'b00 for one byte, 2'b01 for two bytes and 2'b10 for four bytes; 2'b11 acts as four bytes. With BIG_ENDIAN=1, the write data presented downstream is the low N bytes of `req_wdata` in reversed byte order, zero above them.
- R7: With BIG_ENDIAN=1, `done_rdata` for a forwarded read is the low N bytes of `dn_rdata` in reversed byte order, zero above them.
- R8: `dn_valid` stays high with address, direction, length and data stable until `dn_ready`. `req_ready` is low from acceptance until completion, so only one transaction is in flight.
- R9: After reset, `req_ready` is high and `dn_valid` and `done` are low. A reset during a transaction abandons it.
- R10: Each accepted request produces exactly one single-cycle `done` pulse. `done_rdata` is zero for writes.

The downstream address under R3 is assembled as follows.

| Address bits | Source |
|---|---|
| [15:11] and up | binary index of the lowest set bit of raw [31:11] |
| [10:8] | raw bits [10:8] (function number) |
| [7:3] | raw bits [7:3] (register) |
| [2:0] | data-port address bits [2:0] |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_raw | input | ADDR_W | Raw configuration address word held by the bridge |
| req_valid | input | 1 | Data-port access request |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | PORT_W | Low data-port address bits |
| req_len | input | 2 | Access length code |
| req_wdata | input | DATA_W | Write data as seen by the processor |
| done | output | 1 | Single-cycle completion pulse |
| done_abort | output | 1 | Completion was a master abort |
| done_rdata | output | DATA_W | Read result, valid with `done` |
| dn_valid | output | 1 | Downstream transaction valid |
| dn_ready | input | 1 | Downstream accepts the transaction |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | ADDR_W | Translated configuration address |
| dn_len | output | 2 | Downstream length code |
| dn_wdata | output | DATA_W | Lane-ordered write data |
| dn_rvalid | input | 1 | Downstream read data returned |
| dn_rdata | input | DATA_W | Downstream read data |

## Verification
The translation is exercised with the following raw words:
- pass-through words, including one that also has bit 0 set, which separates the priority of bit 31 from the remote-bus form;
- remote-bus words whose low bits differ from the port bits, which shows that the raw bits [2:0] are replaced rather than merged;
- slot-select words with a single slot bit at the bottom and at the top of the field, and one with two slot bits, which tells a lowest-bit encoder from a highest-bit one;
- empty slot fields, read and write, which confirm that nothing reaches downstream and a read returns all ones.

The test runs every access length, so a swap that ignores length or fails to zero-fill shows up. A reset in the middle of a transaction checks that the request is abandoned cleanly.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   typedef enum logic [1:0] {
      CFGX_LEN_B1 = 2'b00,
      CFGX_LEN_B2 = 2'b01,
      CFGX_LEN_B4 = 2'b10,
      CFGX_LEN_RSV = 2'b11
   } cfgx_len_e;

   typedef enum logic [1:0] {
      CFGX_IDLE,
      CFGX_ISSUE,
      CFGX_WAIT,
      CFGX_RESP
   } cfgx_state_e;

   typedef enum logic [1:0] {
      CFGX_FMT_PASS,
      CFGX_FMT_REMOTE,
      CFGX_FMT_SLOT
   } cfgx_fmt_e;

   function automatic int unsigned cfgx_len_bytes(logic [1:0] code);
      case (code)
         CFGX_LEN_B1: return 1;
         CFGX_LEN_B2: return 2;
         default:     return 4;
      endcase
   endfunction

endpackage

// File: rtl/cfgx_lowbit_enc.sv
module cfgx_lowbit_enc #(
   parameter int W  = 21,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          hit
);

   initial begin
      if (W < 2) $error("cfgx_lowbit_enc: W must be at least 2");
   end

   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
      hit = |vec;
   end

endmodule

// File: rtl/cfgx_addr_map.sv
module cfgx_addr_map
   import cfgx_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int PORT_W   = 3,
   parameter int FUNC_LSB = 8,
   parameter int SLOT_LSB = 11
) (
   input  logic [ADDR_W-1:0] raw,
   input  logic [PORT_W-1:0] port,
   output logic [ADDR_W-1:0] xaddr,
   output logic              no_target
);

   localparam int SLOT_N  = ADDR_W - SLOT_LSB;
   localparam int SLOT_IW = $clog2(SLOT_N);
   localparam int ENB     = ADDR_W - 1;
   localparam int PASS_W  = PORT_W - 1;

   cfgx_fmt_e          fmt;
   logic [SLOT_IW-1:0] slot_idx;
   logic               slot_hit;
   logic [ADDR_W-1:0]  pass_addr, remote_addr, slot_addr;

   cfgx_lowbit_enc #(.W(SLOT_N), .IW(SLOT_IW)) u_slot_enc (
      .vec (raw[ADDR_W-1:SLOT_LSB]),
      .idx (slot_idx),
      .hit (slot_hit)
   );

   always_comb begin
      if (raw[ENB])      fmt = CFGX_FMT_PASS;
      else if (raw[0])   fmt = CFGX_FMT_REMOTE;
      else               fmt = CFGX_FMT_SLOT;
   end

   always_comb begin
      pass_addr   = raw | {{(ADDR_W-PASS_W){1'b0}}, port[PASS_W-1:0]};
      remote_addr = {raw[ADDR_W-1:PORT_W], port};
      slot_addr   = '0;
      slot_addr[SLOT_LSB-1:FUNC_LSB] = raw[SLOT_LSB-1:FUNC_LSB];
      slot_addr[FUNC_LSB-1:PORT_W]   = raw[FUNC_LSB-1:PORT_W];
      slot_addr[PORT_W-1:0]          = port;
      slot_addr = slot_addr | (ADDR_W'(slot_idx) << SLOT_LSB);
   end

   always_comb begin
      case (fmt)
         CFGX_FMT_PASS:   xaddr = pass_addr;
         CFGX_FMT_REMOTE: xaddr = remote_addr;
         default:         xaddr = slot_addr;
      endcase
      no_target = (fmt == CFGX_FMT_SLOT) && !slot_hit;
   end

endmodule

// File: rtl/cfgx_lane_swap.sv
module cfgx_lane_swap
   import cfgx_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [1:0]        len,
   output logic [DATA_W-1:0] dout
);

   localparam int NB = DATA_W / 8;

   generate
      if (BIG_ENDIAN) begin : g_rev
         always_comb begin
            int unsigned n;
            n = cfgx_len_bytes(len);
            dout = '0;
            for (int i = 0; i < NB; i++) begin
               if (i < int'(n)) dout[8*i +: 8] = din[8*(int'(n)-1-i) +: 8];
            end
         end
      end else begin : g_keep
         always_comb begin
            int unsigned n;
            n = cfgx_len_bytes(len);
            dout = '0;
            for (int i = 0; i < NB; i++) begin
               if (i < int'(n)) dout[8*i +: 8] = din[8*i +: 8];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cfgx_bridge.sv
module cfgx_bridge
   import cfgx_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int PORT_W     = 3,
   parameter int FUNC_LSB   = 8,
   parameter int SLOT_LSB   = 11,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_raw,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [PORT_W-1:0] req_port,
   input  logic [1:0]        req_len,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic              done_abort,
   output logic [DATA_W-1:0] done_rdata,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic              dn_write,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [1:0]        dn_len,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_rvalid,
   input  logic [DATA_W-1:0] dn_rdata
);

   generate
      if (DATA_W != 32) begin : g_bad_data
         initial $error("cfgx_bridge: DATA_W must be 32 for 4-byte accesses");
      end
      if (PORT_W != 3) begin : g_bad_port
         initial $error("cfgx_bridge: PORT_W must be 3");
      end
      if (FUNC_LSB <= PORT_W || SLOT_LSB != FUNC_LSB + 3) begin : g_bad_field
         initial $error("cfgx_bridge: field layout is inconsistent");
      end
      if (ADDR_W < SLOT_LSB + 2) begin : g_bad_addr
         initial $error("cfgx_bridge: ADDR_W too small for slot field");
      end
   endgenerate

   cfgx_state_e       state;
   logic [ADDR_W-1:0] xaddr, addr_q;
   logic              no_target;
   logic [DATA_W-1:0] wsw, rsw, wdata_q, rdata_q;
   logic              wr_q, abort_q;
   logic [1:0]        len_q;
   logic              accept;

   cfgx_addr_map #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .FUNC_LSB(FUNC_LSB), .SLOT_LSB(SLOT_LSB)
   ) u_map (
      .raw       (cfg_raw),
      .port      (req_port),
      .xaddr     (xaddr),
      .no_target (no_target)
   );

   cfgx_lane_swap #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_wr_swap (
      .din  (req_wdata),
      .len  (req_len),
      .dout (wsw)
   );

   cfgx_lane_swap #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_rd_swap (
      .din  (dn_rdata),
      .len  (len_q),
      .dout (rsw)
   );

   assign accept = req_valid && (state == CFGX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= CFGX_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         wr_q    <= 1'b0;
         abort_q <= 1'b0;
         len_q   <= CFGX_LEN_B1;
      end else begin
         case (state)
            CFGX_IDLE: begin
               if (accept) begin
                  addr_q  <= xaddr;
                  wr_q    <= req_write;
                  len_q   <= req_len;
                  wdata_q <= wsw;
                  abort_q <= no_target;
                  rdata_q <= (no_target && !req_write) ? '1 : '0;
                  state   <= no_target ? CFGX_RESP : CFGX_ISSUE;
               end
            end
            CFGX_ISSUE: begin
               if (dn_ready) state <= wr_q ? CFGX_RESP : CFGX_WAIT;
            end
            CFGX_WAIT: begin
               if (dn_rvalid) begin
                  rdata_q <= rsw;
                  state   <= CFGX_RESP;
               end
            end
            default: state <= CFGX_IDLE;
         endcase
      end
   end

   assign req_ready  = (state == CFGX_IDLE);
   assign dn_valid   = (state == CFGX_ISSUE);
   assign dn_write   = wr_q;
   assign dn_addr    = addr_q;
   assign dn_len     = len_q;
   assign dn_wdata   = wdata_q;
   assign done       = (state == CFGX_RESP);
   assign done_abort = done && abort_q;
   assign done_rdata = rdata_q;

endmodule

// File: rtl/cfgx_bridge_chk.sv
module cfgx_bridge_chk #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int SLOT_LSB = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cfg_raw,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [1:0]        port_lo,
   input logic              done,
   input logic              done_abort,
   input logic [DATA_W-1:0] done_rdata,
   input logic              dn_valid,
   input logic              dn_ready,
   input logic              dn_write,
   input logic [ADDR_W-1:0] dn_addr,
   input logic [1:0]        dn_len,
   input logic [DATA_W-1:0] dn_wdata
);

   logic accept, lat_wr, empty_slot;

   assign accept     = req_valid && req_ready;
   assign empty_slot = !cfg_raw[ADDR_W-1] && !cfg_raw[0] &&
                       (cfg_raw[ADDR_W-2:SLOT_LSB] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_wr <= 1'b0;
      else if (accept) lat_wr <= req_write;
   end

   assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      accept && cfg_raw[ADDR_W-1] |=>
         dn_valid && dn_addr == ($past(cfg_raw) | {{(ADDR_W-2){1'b0}}, $past(port_lo)}));

   assert_abort_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept && empty_slot |=> !dn_valid && done && done_abort);

   assert_abort_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_abort && !lat_wr |-> done_rdata == '1);

   assert_remote_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !cfg_raw[ADDR_W-1] && cfg_raw[0] |=> dn_valid);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ready |=>
         dn_valid && $stable(dn_addr) && $stable(dn_wdata) &&
         $stable(dn_write) && $stable(dn_len));

   assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> !req_ready);

   assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_wr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done && lat_wr |-> done_rdata == '0);

endmodule

bind cfgx_bridge cfgx_bridge_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_LSB(SLOT_LSB)
) chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_raw    (cfg_raw),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_write  (req_write),
   .port_lo    (req_port[1:0]),
   .done       (done),
   .done_abort (done_abort),
   .done_rdata (done_rdata),
   .dn_valid   (dn_valid),
   .dn_ready   (dn_ready),
   .dn_write   (dn_write),
   .dn_addr    (dn_addr),
   .dn_len     (dn_len),
   .dn_wdata   (dn_wdata)
);

// File: tb/cfgx_bridge_test.sv
module cfgx_bridge_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_raw = '0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [2:0]  req_port = '0;
   logic [1:0]  req_len = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, done, done_abort, dn_valid, dn_write;
   logic [31:0] done_rdata, dn_addr, dn_wdata;
   logic [1:0]  dn_len;
   logic        dn_ready = 1'b0, dn_rvalid = 1'b0;
   logic [31:0] dn_rdata = '0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cfgx_bridge uut (
      .clk(clk), .rst_n(rst_n), .cfg_raw(cfg_raw),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_port(req_port), .req_len(req_len), .req_wdata(req_wdata),
      .done(done), .done_abort(done_abort), .done_rdata(done_rdata),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
      .dn_addr(dn_addr), .dn_len(dn_len), .dn_wdata(dn_wdata),
      .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
   );

   typedef struct packed {
      logic [31:0] raw;
      logic [2:0]  port;
      logic        wr;
      logic [1:0]  len;
      logic [31:0] wdata;
      logic [31:0] eaddr;
      logic [31:0] ewdata;
      logic        abort;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t TBL [NV] = '{
      // R1 pass-through, port bit 2 ignored; R6 4-byte swap
      '{32'h8000_1A00, 3'b111, 1'b1, 2'b10, 32'h1122_3344, 32'h8000_1A03, 32'h4433_2211, 1'b0},
      // R1 read, 2 bytes; R7
      '{32'h8000_2310, 3'b010, 1'b0, 2'b01, 32'h0,         32'h8000_2312, 32'h0,         1'b0},
      // R1 priority over bit 0
      '{32'h8000_0001, 3'b110, 1'b0, 2'b00, 32'h0,         32'h8000_0003, 32'h0,         1'b0},
      // R2/R5 remote form, 1-byte write
      '{32'h0001_4A05, 3'b110, 1'b1, 2'b00, 32'hDEAD_BEAF, 32'h0001_4A06, 32'h0000_00AF, 1'b0},
      // R2 remote read, 4 bytes
      '{32'h00FF_0103, 3'b001, 1'b0, 2'b10, 32'h0,         32'h00FF_0101, 32'h0,         1'b0},
      // R3 slot 0, func 5, 2-byte write
      '{32'h0000_0D3C, 3'b010, 1'b1, 2'b01, 32'h0000_BEEF, 32'h0000_053A, 32'h0000_EFBE, 1'b0},
      // R3 two slot bits (14, 20): lowest wins -> slot 3
      '{32'h0010_4210, 3'b101, 1'b0, 2'b10, 32'h0,         32'h0000_1A15, 32'h0,         1'b0},
      // R3 top slot bit 30 -> slot 19
      '{32'h4000_07F8, 3'b000, 1'b1, 2'b10, 32'h0102_0304, 32'h0000_9FF8, 32'h0403_0201, 1'b0},
      // R4 empty slot write
      '{32'h0000_07FC, 3'b011, 1'b1, 2'b10, 32'hCAFE_F00D, 32'h0,         32'h0,         1'b1},
      // R4 empty slot read 4 bytes
      '{32'h0000_0000, 3'b000, 1'b0, 2'b10, 32'h0,         32'h0,         32'h0,         1'b1},
      // R4 empty slot read 1 byte
      '{32'h0000_0304, 3'b001, 1'b0, 2'b00, 32'h0,         32'h0,         32'h0,         1'b1}
   };

   function automatic logic [31:0] model_rd(logic [31:0] a);
      return a ^ 32'hC3C3_5A5A;
   endfunction

   function automatic logic [31:0] rev_len(logic [31:0] m, logic [1:0] len);
      case (len)
         2'b00:   return {24'h0, m[7:0]};
         2'b01:   return {16'h0, m[7:0], m[15:8]};
         default: return {m[7:0], m[15:8], m[23:16], m[31:24]};
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input int k);
      vec_t v;
      logic [31:0] erd;
      v = TBL[k];
      @(negedge clk);
      cfg_raw = v.raw; req_port = v.port; req_write = v.wr;
      req_len = v.len; req_wdata = v.wdata; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      cfg_raw = 32'hFFFF_FFFF;
      if (v.abort) begin
         check(dn_valid == 1'b0, "R4 no downstream on empty slot", 32'(dn_valid), 32'h0);
         check(done && done_abort, "R4 abort completion", {30'h0, done, done_abort}, 32'h3);
         erd = v.wr ? 32'h0 : 32'hFFFF_FFFF;
         check(done_rdata == erd, "R4 abort read data", done_rdata, erd);
      end else begin
         check(dn_valid == 1'b1, "R5 forwarded", 32'(dn_valid), 32'h1);
         check(dn_addr == v.eaddr, "R1/R2/R3 translated address", dn_addr, v.eaddr);
         check(dn_write == v.wr && dn_len == v.len, "R8 direction and length",
               {29'h0, dn_write, dn_len}, {29'h0, v.wr, v.len});
         if (v.wr) check(dn_wdata == v.ewdata, "R6 write lane order", dn_wdata, v.ewdata);
         @(negedge clk);
         check(dn_valid && !req_ready && dn_addr == v.eaddr, "R8 hold while not ready",
               dn_addr, v.eaddr);
         dn_ready = 1'b1;
         @(negedge clk);
         dn_ready = 1'b0;
         if (!v.wr) begin
            check(done == 1'b0, "R10 no done before read data", 32'(done), 32'h0);
            dn_rvalid = 1'b1;
            dn_rdata  = model_rd(v.eaddr);
            @(negedge clk);
            dn_rvalid = 1'b0;
            dn_rdata  = 32'h0;
         end
         erd = v.wr ? 32'h0 : rev_len(model_rd(v.eaddr), v.len);
         check(done && !done_abort, "R10 completion pulse", {30'h0, done, done_abort}, 32'h2);
         check(done_rdata == erd, "R7 read lane order", done_rdata, erd);
      end
      @(negedge clk);
      check(!done && req_ready, "R10 single pulse, back to idle",
            {30'h0, done, req_ready}, 32'h1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R10 actual=%h expected=%h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(req_ready && !dn_valid && !done, "R9 reset state",
            {29'h0, req_ready, dn_valid, done}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !dn_valid && !done, "R9 idle after reset release",
            {29'h0, req_ready, dn_valid, done}, 32'h4);

      for (int k = 0; k < NV; k++) run_vec(k);

      // R9: reset in the middle of a forwarded transaction
      @(negedge clk);
      cfg_raw = 32'h0000_2105; req_port = 3'b000; req_write = 1'b1;
      req_len = 2'b10; req_wdata = 32'h5555_AAAA; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(dn_valid == 1'b1, "R9 transaction in flight", 32'(dn_valid), 32'h1);
      rst_n = 1'b0;
      @(negedge clk);
      check(!dn_valid && req_ready && !done, "R9 reset abandons transaction",
            {29'h0, req_ready, dn_valid, done}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(!dn_valid && !done, "R9 nothing resumes after reset",
            {30'h0, dn_valid, done}, 32'h0);

      // R8: request held high while busy is taken only once per completion
      cfg_raw = 32'h8000_0040; req_port = 3'b000; req_write = 1'b1;
      req_len = 2'b10; req_wdata = 32'h0; req_valid = 1'b1;
      @(negedge clk);
      check(dn_valid && !req_ready, "R8 busy blocks further requests",
            {30'h0, dn_valid, req_ready}, 32'h2);
      req_valid = 1'b0;
      dn_ready = 1'b1;
      @(negedge clk);
      dn_ready = 1'b0;
      check(done == 1'b1, "R10 write completion", 32'(done), 32'h1);
      @(negedge clk);
      check(!dn_valid && req_ready, "R8 idle after single transaction",
            {30'h0, dn_valid, req_ready}, 32'h1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule